// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns the 16-bit logical addresses of a 16-bit controller into 24-bit physical addresses. Data accesses normally go through one of four page pointer registers. The top two bits of the logical address pick the register. Each register holds a 10-bit page number for a 16 KB page. A data access can instead bring its own page number, or its own 8-bit number for a 64 KB segment. Code fetches join an 8-bit code segment register with the 16-bit instruction pointer.

The pointer registers and the code segment register are loaded through a plain register write port. Data requests and code fetch requests each enter on a valid/ready channel. Each returns its physical address one cycle later through a registered valid/ready response channel. A channel accepts a new request when its response register is empty or is being drained in the same cycle (`ready = !rsp_valid || rsp_ready`). While the consumer holds ready low, a held response keeps both its valid and its address.

The code segment never advances by itself. Only a far branch fetch loads a new segment. When a sequential fetch follows a fetch at instruction pointer 16'hFFFF, the block raises a one-cycle `boundary_error` pulse. The fetch address stays inside the current segment.

Top module: `pat_unit`

## Requirements
- R1: After reset, all four page pointers and the code segment are zero, `drsp_valid`, `crsp_valid` and `boundary_error` are low, and the first translations land in page 0 and segment 0.
- R2: With `dreq_mode` 2'b00 (and also with the spare code 2'b11), the physical address is {pointer[addr[15:14]], addr[13:0]}.
- R3: With `dreq_mode` 2'b01, the physical address is {dreq_ovr[9:0], addr[13:0]}, and no pointer register is used.
- R4: With `dreq_mode` 2'b10, the physical address is {dreq_ovr[7:0], addr[15:0]}, and dreq_ovr[9:8] is ignored.
- R5: Logical addresses 16'h3FFF and 16'h4000 go through pointers 0 and 1 respectively, so their physical addresses need not be adjacent.
- R6: The write port loads pointer n when `wr_sel`=n (0..3) and loads the code segment from wr_data[7:0] when `wr_sel`=4. Codes 5..7 change nothing. A translation in the same cycle as a write sees the old value.
- R7: A request accepted at a clock edge shows its address, with response valid high, right after that edge (one cycle of latency).
- R8: While a response is valid and its ready is low, the response keeps its valid and its address, and the request ready is low.
- R9: A code fetch address is {code_segment, fetch_ip}. Fetches other than a far branch never change the segment.
- R10: An accepted fetch with `fetch_far` high uses `fetch_seg` for its own address and loads it as the code segment for the fetches after it. It wins over a code segment write in the same cycle.
- R11: If the previous accepted fetch had IP 16'hFFFF and the current accepted fetch has neither `fetch_branch` nor `fetch_far`, `boundary_error` is high for exactly the one cycle in which that fetch's response first appears. The address keeps the current segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target: 0..3 page pointer, 4 code segment |
| wr_data | input | 10 | Write value |
| dreq_valid | input | 1 | Data request valid |
| dreq_ready | output | 1 | Data request accepted |
| dreq_addr | input | 16 | Logical data address |
| dreq_mode | input | 2 | 00 pointer, 01 page override, 10 segment override, 11 as 00 |
| dreq_ovr | input | 10 | Override page or segment number |
| drsp_valid | output | 1 | Data response valid |
| drsp_ready | input | 1 | Data response consumed |
| drsp_addr | output | 24 | Physical data address |
| fetch_valid | input | 1 | Code fetch request valid |
| fetch_ready | output | 1 | Code fetch accepted |
| fetch_ip | input | 16 | Instruction pointer |
| fetch_branch | input | 1 | Fetch follows a branch within the segment |
| fetch_far | input | 1 | Far branch: load segment from fetch_seg |
| fetch_seg | input | 8 | New segment for a far branch |
| crsp_valid | output | 1 | Code response valid |
| crsp_ready | input | 1 | Code response consumed |
| crsp_addr | output | 24 | Physical fetch address |
| boundary_error | output | 1 | Pulse: sequential fetch ran past segment end |

## Verification
The hardest case to reach from the ports is the segment-end error. It needs an accepted fetch at 16'hFFFF and then an accepted sequential fetch, and a branch or far fetch in between must cancel it. The stimulus walks the IP through 16'hFFFE, 16'hFFFF and 16'h0000, then repeats the walk with a near branch and again across a far branch. The old-value rule for writes is reached by driving a pointer write and a translation through the same pointer in one cycle. Back-pressure is reached by holding response ready low while a second request is offered.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int LA_W   = 16;                 // logical address width
  localparam int PAGE_W = 10;                 // page number width
  localparam int SEG_W  = 8;                  // segment number width
  localparam int NPTR   = 4;                  // page pointer count
  localparam int SELB   = $clog2(NPTR);       // pointer index bits
  localparam int OFS_W  = LA_W - SELB;        // in-page offset width
  localparam int PA_W   = SEG_W + LA_W;       // physical address width
  localparam int SEL_W  = $clog2(NPTR + 1);   // write select width

  typedef enum logic [1:0] {
    XM_PTR  = 2'b00,
    XM_PAGE = 2'b01,
    XM_SEG  = 2'b10,
    XM_RSVD = 2'b11
  } xmode_e;
endpackage

// File: rtl/pat_ptr_regs.sv
module pat_ptr_regs
  import pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic              far_load,
  input  logic [SEG_W-1:0]  far_seg,
  output logic [PAGE_W-1:0] dpp [NPTR],
  output logic [SEG_W-1:0]  csp
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [PAGE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_sel == SEL_W'(i)) q <= wr_data;
    end
    assign dpp[i] = q;
  end

  logic [SEG_W-1:0] csp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csp_q <= '0;
    else if (far_load) csp_q <= far_seg;
    else if (wr_en && wr_sel == SEL_W'(NPTR)) csp_q <= wr_data[SEG_W-1:0];
  end
  assign csp = csp_q;
endmodule

// File: rtl/pat_data_path.sv
module pat_data_path
  import pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_addr,
  input  logic [1:0]        req_mode,
  input  logic [PAGE_W-1:0] req_ovr,
  input  logic [PAGE_W-1:0] dpp [NPTR],
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_addr
);
  logic [SELB-1:0] idx;
  logic [PA_W-1:0] nxt;
  logic            fire;

  assign idx = req_addr[LA_W-1 -: SELB];

  always_comb begin
    case (xmode_e'(req_mode))
      XM_PAGE: nxt = {req_ovr, req_addr[OFS_W-1:0]};
      XM_SEG:  nxt = {req_ovr[SEG_W-1:0], req_addr};
      default: nxt = {dpp[idx], req_addr[OFS_W-1:0]};
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pat_code_path.sv
module pat_code_path
  import pat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_ip,
  input  logic             req_branch,
  input  logic             req_far,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [SEG_W-1:0] csp,
  output logic             far_load,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_addr,
  output logic             seg_err
);
  logic             fire;
  logic             last_top;
  logic [SEG_W-1:0] seg_now;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign far_load  = fire && req_far;
  assign seg_now   = req_far ? req_seg : csp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      last_top  <= 1'b0;
      seg_err   <= 1'b0;
    end else begin
      seg_err <= 1'b0;
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_addr  <= {seg_now, req_ip};
        last_top  <= &req_ip;
        seg_err   <= last_top && !req_branch && !req_far;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pat_unit.sv
module pat_unit
  import pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic              dreq_valid,
  output logic              dreq_ready,
  input  logic [LA_W-1:0]   dreq_addr,
  input  logic [1:0]        dreq_mode,
  input  logic [PAGE_W-1:0] dreq_ovr,
  output logic              drsp_valid,
  input  logic              drsp_ready,
  output logic [PA_W-1:0]   drsp_addr,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [LA_W-1:0]   fetch_ip,
  input  logic              fetch_branch,
  input  logic              fetch_far,
  input  logic [SEG_W-1:0]  fetch_seg,
  output logic              crsp_valid,
  input  logic              crsp_ready,
  output logic [PA_W-1:0]   crsp_addr,
  output logic              boundary_error
);
  logic [PAGE_W-1:0] dpp [NPTR];
  logic [SEG_W-1:0]  csp;
  logic              far_load;

  pat_ptr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .far_load(far_load), .far_seg(fetch_seg), .dpp(dpp), .csp(csp)
  );

  pat_data_path u_data (
    .clk(clk), .rst_n(rst_n), .req_valid(dreq_valid), .req_ready(dreq_ready),
    .req_addr(dreq_addr), .req_mode(dreq_mode), .req_ovr(dreq_ovr), .dpp(dpp),
    .rsp_valid(drsp_valid), .rsp_ready(drsp_ready), .rsp_addr(drsp_addr)
  );

  pat_code_path u_code (
    .clk(clk), .rst_n(rst_n), .req_valid(fetch_valid), .req_ready(fetch_ready),
    .req_ip(fetch_ip), .req_branch(fetch_branch), .req_far(fetch_far),
    .req_seg(fetch_seg), .csp(csp), .far_load(far_load),
    .rsp_valid(crsp_valid), .rsp_ready(crsp_ready), .rsp_addr(crsp_addr),
    .seg_err(boundary_error)
  );
endmodule

// File: rtl/pat_unit_sva.sv
module pat_unit_sva
  import pat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dreq_valid,
  input logic             dreq_ready,
  input logic [LA_W-1:0]  dreq_addr,
  input logic             drsp_valid,
  input logic             drsp_ready,
  input logic [PA_W-1:0]  drsp_addr,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic             fetch_far,
  input logic [SEG_W-1:0] fetch_seg,
  input logic             crsp_valid,
  input logic             crsp_ready,
  input logic [PA_W-1:0]  crsp_addr,
  input logic             boundary_error
);
  AST_DATA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && dreq_ready |=> drsp_valid); // R7
  AST_DATA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && dreq_ready |=> drsp_addr[OFS_W-1:0] == $past(dreq_addr[OFS_W-1:0])); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drsp_valid && !drsp_ready |=> drsp_valid && $stable(drsp_addr)); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    crsp_valid && !crsp_ready |=> crsp_valid && $stable(crsp_addr)); // R8
  AST_FAR_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && fetch_far |=> crsp_addr[PA_W-1 -: SEG_W] == $past(fetch_seg)); // R10
  AST_ERR_WITH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_error |-> crsp_valid); // R11
endmodule

bind pat_unit pat_unit_sva u_sva (
  .clk(clk), .rst_n(rst_n), .dreq_valid(dreq_valid), .dreq_ready(dreq_ready),
  .dreq_addr(dreq_addr), .drsp_valid(drsp_valid), .drsp_ready(drsp_ready),
  .drsp_addr(drsp_addr), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_far(fetch_far), .fetch_seg(fetch_seg), .crsp_valid(crsp_valid),
  .crsp_ready(crsp_ready), .crsp_addr(crsp_addr), .boundary_error(boundary_error)
);

// File: tb/pat_unit_test.sv
module pat_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [9:0]  wr_data = '0;
  logic        dreq_valid = 1'b0;
  logic        dreq_ready;
  logic [15:0] dreq_addr = '0;
  logic [1:0]  dreq_mode = '0;
  logic [9:0]  dreq_ovr = '0;
  logic        drsp_valid;
  logic        drsp_ready = 1'b1;
  logic [23:0] drsp_addr;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [15:0] fetch_ip = '0;
  logic        fetch_branch = 1'b0;
  logic        fetch_far = 1'b0;
  logic [7:0]  fetch_seg = '0;
  logic        crsp_valid;
  logic        crsp_ready = 1'b1;
  logic [23:0] crsp_addr;
  logic        boundary_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pat_unit uut (.*);

  // {mode[1:0], ovr[9:0], addr[15:0], expected[23:0]}
  localparam logic [51:0] VEC [0:8] = '{
    {2'b00, 10'h000, 16'h1234, 24'h005234},
    {2'b00, 10'h000, 16'h4000, 24'h554000},
    {2'b00, 10'h000, 16'h3FFF, 24'h007FFF},
    {2'b00, 10'h000, 16'h8001, 24'hAA8001},
    {2'b00, 10'h000, 16'hFFFF, 24'hFFFFFF},
    {2'b01, 10'h0A3, 16'hC123, 24'h28C123},
    {2'b10, 10'h07E, 16'hBEEF, 24'h7EBEEF},
    {2'b10, 10'h37E, 16'hBEEF, 24'h7EBEEF},
    {2'b11, 10'h000, 16'h8002, 24'hAA8002}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic dtx(input logic [15:0] a, input logic [1:0] m, input logic [9:0] o);
    @(negedge clk);
    dreq_valid = 1'b1; dreq_addr = a; dreq_mode = m; dreq_ovr = o;
    @(negedge clk);
    dreq_valid = 1'b0;
  endtask

  task automatic ftx(input logic [15:0] ip, input logic br, input logic far, input logic [7:0] seg);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_ip = ip; fetch_branch = br; fetch_far = far; fetch_seg = seg;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_branch = 1'b0; fetch_far = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset and just after
    chk("R1 drsp_valid", drsp_valid, 0);
    chk("R1 crsp_valid", crsp_valid, 0);
    chk("R1 boundary_error", boundary_error, 0);
    rst_n = 1'b1;
    dtx(16'h8005, 2'b00, 10'h0);
    chk("R1 zero page", drsp_addr, 24'h000005);
    ftx(16'h0100, 1'b0, 1'b0, 8'h0);
    chk("R1 zero segment", crsp_addr, 24'h000100);

    // R6: write and translate through pointer 1 in the same cycle -> old value
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 10'h155;
    dreq_valid = 1'b1; dreq_addr = 16'h4ABC; dreq_mode = 2'b00;
    @(negedge clk);
    wr_en = 1'b0; dreq_valid = 1'b0;
    chk("R6 old value in write cycle", drsp_addr, 24'h000ABC);
    dtx(16'h4ABC, 2'b00, 10'h0);
    chk("R6 new value next cycle", drsp_addr, 24'h554ABC);

    wr(3'd0, 10'h001);
    wr(3'd2, 10'h2AA);
    wr(3'd3, 10'h3FF);
    wr(3'd4, 10'h312);   // R6: segment takes bits [7:0] -> 8'h12

    // R2 R3 R4 table walk
    for (int i = 0; i < 9; i++) begin
      logic [51:0] v;
      v = VEC[i];
      dtx(v[39:24], v[51:50], v[49:40]);
      chk("R7 response valid", drsp_valid, 1);
      if (v[51:50] == 2'b01)      chk("R3 page override", drsp_addr, v[23:0]);
      else if (v[51:50] == 2'b10) chk("R4 segment override", drsp_addr, v[23:0]);
      else                        chk("R2 pointer select", drsp_addr, v[23:0]);
    end

    // R5: across the 16 KB boundary the pages differ
    dtx(16'h3FFF, 2'b00, 10'h0);
    chk("R5 below boundary", drsp_addr, 24'h007FFF);
    dtx(16'h4000, 2'b00, 10'h0);
    chk("R5 above boundary", drsp_addr, 24'h554000);

    // R6: spare select codes change nothing
    wr(3'd5, 10'h3C3);
    wr(3'd7, 10'h0F0);
    dtx(16'h1234, 2'b00, 10'h0);
    chk("R6 spare select data path", drsp_addr, 24'h005234);
    ftx(16'h2000, 1'b0, 1'b0, 8'h0);
    chk("R6 R9 segment after write", crsp_addr, 24'h122000);

    // R9 R11: sequential walk through segment end
    ftx(16'hFFFE, 1'b0, 1'b0, 8'h99);
    chk("R9 seg kept", crsp_addr, 24'h12FFFE);
    chk("R11 no error", boundary_error, 0);
    ftx(16'hFFFF, 1'b0, 1'b0, 8'h0);
    chk("R11 no error at top", boundary_error, 0);
    ftx(16'h0000, 1'b0, 1'b0, 8'h0);
    chk("R11 wrap in segment", crsp_addr, 24'h120000);
    chk("R11 error pulse", boundary_error, 1);
    @(negedge clk);
    chk("R11 pulse one cycle", boundary_error, 0);
    ftx(16'h0001, 1'b0, 1'b0, 8'h0);
    chk("R11 no repeat", boundary_error, 0);

    // R11: near branch after top clears the error
    ftx(16'hFFFF, 1'b0, 1'b0, 8'h0);
    ftx(16'h0000, 1'b1, 1'b0, 8'h0);
    chk("R11 branch no error", boundary_error, 0);

    // R10: far branch after top, new segment applies at once and after
    ftx(16'hFFFF, 1'b0, 1'b0, 8'h0);
    ftx(16'h0010, 1'b0, 1'b1, 8'h34);
    chk("R10 far address", crsp_addr, 24'h340010);
    chk("R11 far no error", boundary_error, 0);
    ftx(16'h0011, 1'b0, 1'b0, 8'h77);
    chk("R10 segment persists", crsp_addr, 24'h340011);

    // R10: far wins over same-cycle segment write
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 10'h055;
    fetch_valid = 1'b1; fetch_ip = 16'h0200; fetch_far = 1'b1; fetch_seg = 8'h66;
    @(negedge clk);
    wr_en = 1'b0; fetch_valid = 1'b0; fetch_far = 1'b0;
    chk("R10 far address with write", crsp_addr, 24'h660200);
    ftx(16'h0201, 1'b0, 1'b0, 8'h0);
    chk("R10 far beats write", crsp_addr, 24'h660201);

    // R8: back-pressure on the data response
    @(negedge clk);
    drsp_ready = 1'b0;
    dreq_valid = 1'b1; dreq_addr = 16'h1234; dreq_mode = 2'b00;
    @(negedge clk);
    dreq_addr = 16'hFFFF;
    chk("R8 ready low while held", dreq_ready, 0);
    @(negedge clk);
    chk("R8 address held", drsp_addr, 24'h005234);
    chk("R8 valid held", drsp_valid, 1);
    drsp_ready = 1'b1;
    @(negedge clk);
    dreq_valid = 1'b0;
    chk("R8 second request taken", drsp_addr, 24'hFFFFFF);

    // R8: back-pressure on the code response
    @(negedge clk);
    crsp_ready = 1'b0;
    fetch_valid = 1'b1; fetch_ip = 16'h0300;
    @(negedge clk);
    fetch_ip = 16'h0400;
    chk("R8 fetch ready low", fetch_ready, 0);
    @(negedge clk);
    chk("R8 fetch address held", crsp_addr, 24'h660300);
    crsp_ready = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R8 second fetch taken", crsp_addr, 24'h660400);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule